// File: doc/BRIEF.md
# Power Mode Transition Controller

This block holds the operating mode of a processor subsystem and picks the next mode whenever a sleep request arrives. The mode is one of high-speed, medium-speed, subactive, software standby, watch or plain sleep. The choice depends on a set of control-register bits: standby enable, low-speed select, direct enable, prescaler-source select and clock-change enable.

Certain bit patterns cause a direct run-to-run mode change, in which execution does not halt. A move from high or medium speed to subactive takes effect at once. A move from subactive back to high speed first waits out a programmable settling time. Every direct transition ends with a one-cycle request for direct-transition exception handling. A bit pattern that matches no legal move is refused: the mode stays as it was and a sticky error flag is raised.

The block also holds one module-stop bit per peripheral. A set bit blocks register access to that peripheral. All pins are plain control and status levels. No data stream crosses the boundary, so no valid/ready handshake and no back-pressure apply.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the outputs are as follows. `mode` is 0 (high-speed) and `clk_src` is 0 (main). `settle_busy`, `dtx_pulse` and `err_flag` are 0. `mstp` is all ones except bit `ALWAYS_ON_IDX`, which is 0.
- R2: Mode codes are 0 high-speed, 1 medium-speed, 2 subactive, 3 standby, 4 watch and 5 sleep. Clock codes are 0 main, 1 alternate main and 2 sub. Suppose a sleep request is accepted in mode 0 or 1 with standby=1, low_speed=1, direct=1, presc=1 and clk_chg=0. On the next cycle `mode` is 2 and `clk_src` is 2.
- R3: Suppose a sleep request is accepted in mode 2 with standby=1, low_speed=0, direct=1 and presc=1. `settle_busy` then stays high for exactly 2^(8+settle_code) cycles while `mode` stays 2. After that, `mode` becomes 0 and `clk_src` becomes `alt_clk_sel`.
- R4: `dtx_pulse` is high for exactly one cycle on completion of each direct transition (R2, R3, R7). It is never high after any other request.
- R5: A request with standby=1, direct=0 and presc=1 enters watch (4). With presc=0 it enters standby (3). `clk_src` is unchanged in both cases.
- R6: In standby, or in watch with low_speed=0, a wake-up starts the settling wait of R3. The block then enters mode 0 with `clk_src` equal to `alt_clk_sel`. In watch with low_speed=1, a wake-up enters mode 2 on the next cycle with `clk_src` equal to 2.
- R7: Suppose a request arrives in mode 0 or 1 with standby=1, low_speed=0, direct=1 and clk_chg=1. On the next cycle `clk_src` equals `alt_clk_sel` and the mode is unchanged.
- R8: Any sleep request that matches none of the patterns in R2, R3, R5, R7 and R9 is illegal. This includes low_speed=direct=1 together with clk_chg=1. An illegal request leaves the mode and the clock unchanged and sets `err_flag`. `err_flag` holds until `err_clr` is 1, and a new error in the same cycle as a clear wins.
- R9: A request with standby=0 and direct=0 enters sleep (5). Any wake-up returns the block to the mode it left.
- R10: `mstp_we` loads `mstp_wdata` into `mstp` on the next cycle. `periph_ack[i]` is `periph_req[i]` while `mstp[i]` is 0, and is 0 while `mstp[i]` is 1.
- R11: In mode 0 or 1 with no accepted request, `mode` follows `med_sel` on the next cycle (1 selects medium).
- R12: A sleep request is ignored while `settle_busy` is high and in modes 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Sleep request, one cycle |
| wake_irq | input | 1 | Wake-up interrupt |
| standby_en | input | 1 | Standby enable bit |
| low_speed_sel | input | 1 | Low-speed select bit |
| direct_en | input | 1 | Direct-transition enable bit |
| presc_src_sel | input | 1 | Prescaler-source select bit |
| clk_chg_en | input | 1 | Clock-change enable bit |
| alt_clk_sel | input | 1 | Chosen main clock source (0 main, 1 alternate) |
| med_sel | input | 1 | Medium-speed select while running fast |
| settle_code | input | 3 | Settling-time code |
| err_clr | input | 1 | Write-1 clear of the error flag |
| mstp_we | input | 1 | Module-stop write strobe |
| mstp_wdata | input | NPERIPH | Module-stop write data |
| periph_req | input | NPERIPH | Per-peripheral register access request |
| mode | output | 3 | Current mode code |
| clk_src | output | 2 | System clock source code |
| dtx_pulse | output | 1 | Direct-transition exception request |
| settle_busy | output | 1 | Settling wait in progress |
| err_flag | output | 1 | Sticky illegal-request flag |
| mstp | output | NPERIPH | Module-stop bits |
| periph_ack | output | NPERIPH | Granted register access |

## Verification
The mode and clock registers drive the outputs directly. A wrong decode therefore shows on `mode` or `clk_src` on the cycle after the request, and a missing or extra exception request shows on `dtx_pulse` in that same cycle. An error in the settling counter is only visible when the wait ends: `settle_busy` drops early or late by the size of the miscount, which can be hundreds of cycles after the request. For this reason the bench counts the full busy window. A corrupted module-stop bit shows at once on `periph_ack`.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    MODE_HIGH  = 3'd0,
    MODE_MED   = 3'd1,
    MODE_SUB   = 3'd2,
    MODE_SSTBY = 3'd3,
    MODE_WATCH = 3'd4,
    MODE_SLEEP = 3'd5
  } pmc_mode_e;

  typedef enum logic [1:0] {
    CLK_MAIN = 2'd0,
    CLK_ALT  = 2'd1,
    CLK_SUB  = 2'd2
  } pmc_clk_e;

  typedef enum logic [2:0] {
    ACT_ILLEGAL = 3'd0,
    ACT_SLEEP   = 3'd1,
    ACT_SSTBY   = 3'd2,
    ACT_WATCH   = 3'd3,
    ACT_DT_SUB  = 3'd4,
    ACT_DT_HIGH = 3'd5,
    ACT_DT_CLK  = 3'd6
  } pmc_act_e;

  function automatic logic is_fast(pmc_mode_e m);
    return (m == MODE_HIGH) || (m == MODE_MED);
  endfunction

endpackage

// File: rtl/pmc_sleep_decode.sv
module pmc_sleep_decode
  import pmc_pkg::*;
(
  input  pmc_mode_e mode,
  input  logic      standby_en,
  input  logic      low_speed_sel,
  input  logic      direct_en,
  input  logic      presc_src_sel,
  input  logic      clk_chg_en,
  output pmc_act_e  act
);

  always_comb begin
    act = ACT_ILLEGAL;
    if (is_fast(mode)) begin
      if (!standby_en) begin
        act = direct_en ? ACT_ILLEGAL : ACT_SLEEP;
      end else if (!direct_en) begin
        act = presc_src_sel ? ACT_WATCH : ACT_SSTBY;
      end else if (low_speed_sel) begin
        // subactive move and clock switch together are refused
        if (presc_src_sel && !clk_chg_en) act = ACT_DT_SUB;
        else                              act = ACT_ILLEGAL;
      end else begin
        act = clk_chg_en ? ACT_DT_CLK : ACT_ILLEGAL;
      end
    end else if (mode == MODE_SUB) begin
      if (!standby_en && !direct_en)
        act = ACT_SLEEP;
      else if (standby_en && !low_speed_sel && direct_en && presc_src_sel)
        act = ACT_DT_HIGH;
      else if (standby_en && !direct_en && presc_src_sel)
        act = ACT_WATCH;
      else
        act = ACT_ILLEGAL;
    end
  end

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int BASE_LOG2 = 8,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = BASE_LOG2 + (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [CNT_W:0]   span;

  always_comb begin
    span = (CNT_W + 1)'(1) << (BASE_LOG2 + int'(code));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(span - 1'b1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

endmodule

// File: rtl/pmc_mstp_bank.sv
module pmc_mstp_bank #(
  parameter int NPERIPH       = 8,
  parameter int ALWAYS_ON_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NPERIPH-1:0] wdata,
  input  logic [NPERIPH-1:0] req,
  output logic [NPERIPH-1:0] stop,
  output logic [NPERIPH-1:0] ack
);

  localparam logic [NPERIPH-1:0] RST_VAL = ~(NPERIPH'(1) << ALWAYS_ON_IDX);

  logic [NPERIPH-1:0] stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  stop_q <= RST_VAL;
    else if (we) stop_q <= wdata;
  end

  for (genvar i = 0; i < NPERIPH; i++) begin : g_gate
    assign ack[i] = req[i] & ~stop_q[i];
  end

  assign stop = stop_q;

  p_mstp_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (stop_q == $past(wdata)));

  p_mstp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(stop_q));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NPERIPH       = 8,
  parameter int ALWAYS_ON_IDX = 0,
  parameter int BASE_LOG2     = 8,
  parameter int CODE_W        = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               wake_irq,
  input  logic               standby_en,
  input  logic               low_speed_sel,
  input  logic               direct_en,
  input  logic               presc_src_sel,
  input  logic               clk_chg_en,
  input  logic               alt_clk_sel,
  input  logic               med_sel,
  input  logic [CODE_W-1:0]  settle_code,
  input  logic               err_clr,
  input  logic               mstp_we,
  input  logic [NPERIPH-1:0] mstp_wdata,
  input  logic [NPERIPH-1:0] periph_req,
  output logic [2:0]         mode,
  output logic [1:0]         clk_src,
  output logic               dtx_pulse,
  output logic               settle_busy,
  output logic               err_flag,
  output logic [NPERIPH-1:0] mstp,
  output logic [NPERIPH-1:0] periph_ack
);

  pmc_mode_e mode_q, prior_q;
  pmc_clk_e  clk_q;
  logic      dtx_q, err_q, pend_dt_q;
  pmc_act_e  act;
  logic      busy, done, tmr_start, sleep_acc, illegal_acc;

  pmc_sleep_decode u_dec (
    .mode          (mode_q),
    .standby_en    (standby_en),
    .low_speed_sel (low_speed_sel),
    .direct_en     (direct_en),
    .presc_src_sel (presc_src_sel),
    .clk_chg_en    (clk_chg_en),
    .act           (act)
  );

  pmc_settle_timer #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .code  (settle_code),
    .busy  (busy),
    .done  (done)
  );

  pmc_mstp_bank #(.NPERIPH(NPERIPH), .ALWAYS_ON_IDX(ALWAYS_ON_IDX)) u_mstp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mstp_we),
    .wdata (mstp_wdata),
    .req   (periph_req),
    .stop  (mstp),
    .ack   (periph_ack)
  );

  assign sleep_acc   = sleep_req && !busy && (is_fast(mode_q) || mode_q == MODE_SUB);
  assign illegal_acc = sleep_acc && (act == ACT_ILLEGAL);

  always_comb begin
    tmr_start = 1'b0;
    if (!busy) begin
      if (sleep_acc && act == ACT_DT_HIGH)                          tmr_start = 1'b1;
      if (wake_irq && mode_q == MODE_SSTBY)                         tmr_start = 1'b1;
      if (wake_irq && mode_q == MODE_WATCH && !low_speed_sel)       tmr_start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_HIGH;
      prior_q   <= MODE_HIGH;
      clk_q     <= CLK_MAIN;
      dtx_q     <= 1'b0;
      err_q     <= 1'b0;
      pend_dt_q <= 1'b0;
    end else begin
      dtx_q <= 1'b0;
      if (err_clr) err_q <= 1'b0;
      if (done) begin
        mode_q    <= MODE_HIGH;
        clk_q     <= alt_clk_sel ? CLK_ALT : CLK_MAIN;
        dtx_q     <= pend_dt_q;
        pend_dt_q <= 1'b0;
      end else if (sleep_acc) begin
        unique case (act)
          ACT_SLEEP: begin
            prior_q <= mode_q;
            mode_q  <= MODE_SLEEP;
          end
          ACT_SSTBY: mode_q <= MODE_SSTBY;
          ACT_WATCH: mode_q <= MODE_WATCH;
          ACT_DT_SUB: begin
            mode_q <= MODE_SUB;
            clk_q  <= CLK_SUB;
            dtx_q  <= 1'b1;
          end
          ACT_DT_HIGH: pend_dt_q <= 1'b1;
          ACT_DT_CLK: begin
            clk_q <= alt_clk_sel ? CLK_ALT : CLK_MAIN;
            dtx_q <= 1'b1;
          end
          default: err_q <= 1'b1;
        endcase
      end else if (!busy) begin
        unique case (mode_q)
          MODE_HIGH, MODE_MED: mode_q <= med_sel ? MODE_MED : MODE_HIGH;
          MODE_SLEEP: if (wake_irq) mode_q <= prior_q;
          MODE_WATCH: if (wake_irq && low_speed_sel) begin
            mode_q <= MODE_SUB;
            clk_q  <= CLK_SUB;
          end
          default: ;
        endcase
      end
    end
  end

  assign mode        = mode_q;
  assign clk_src     = clk_q;
  assign dtx_pulse   = dtx_q;
  assign settle_busy = busy;
  assign err_flag    = err_q;

  p_dtx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dtx_q |=> !dtx_q);

  p_sub_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SUB) |-> (clk_q == CLK_SUB));

  p_busy_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode_q == MODE_SUB || mode_q == MODE_SSTBY || mode_q == MODE_WATCH));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_acc |=> (err_q && mode_q == $past(mode_q) && clk_q == $past(clk_q)));

  p_sleep_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP && wake_irq) |=> (mode_q == $past(prior_q)));

  p_dt_needs_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_acc && (act == ACT_DT_SUB || act == ACT_DT_CLK || act == ACT_DT_HIGH))
      |-> direct_en);

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 0, wake_irq = 0;
  logic standby_en = 0, low_speed_sel = 0, direct_en = 0, presc_src_sel = 0, clk_chg_en = 0;
  logic alt_clk_sel = 1, med_sel = 0, err_clr = 0, mstp_we = 0;
  logic [2:0]   settle_code = 3'd0;
  logic [N-1:0] mstp_wdata = '0, periph_req = '0;
  logic [2:0]   mode;
  logic [1:0]   clk_src;
  logic         dtx_pulse, settle_busy, err_flag;
  logic [N-1:0] mstp, periph_ack;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_irq(wake_irq),
    .standby_en(standby_en), .low_speed_sel(low_speed_sel), .direct_en(direct_en),
    .presc_src_sel(presc_src_sel), .clk_chg_en(clk_chg_en), .alt_clk_sel(alt_clk_sel),
    .med_sel(med_sel), .settle_code(settle_code), .err_clr(err_clr),
    .mstp_we(mstp_we), .mstp_wdata(mstp_wdata), .periph_req(periph_req),
    .mode(mode), .clk_src(clk_src), .dtx_pulse(dtx_pulse), .settle_busy(settle_busy),
    .err_flag(err_flag), .mstp(mstp), .periph_ack(periph_ack)
  );

  // {standby, low_speed, direct, presc, clk_chg} | mode | clk | dtx | err
  localparam logic [11:0] VEC [10] = '{
    12'b00000_101_00_0_0,  // R9 plain sleep
    12'b10000_011_00_0_0,  // R5 standby
    12'b10010_100_00_0_0,  // R5 watch
    12'b11110_010_10_1_0,  // R2 direct to subactive
    12'b11111_000_00_0_1,  // R8 subactive plus clock switch
    12'b11100_000_00_0_1,  // R8 direct without prescaler source
    12'b00100_000_00_0_1,  // R8 direct without standby
    12'b10101_000_01_1_0,  // R7 direct clock switch
    12'b10100_000_00_0_1,  // R8 direct with nothing to do
    12'b11010_100_00_0_0   // R5 direct clear, low-speed ignored
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sleep_req = 0; wake_irq = 0; err_clr = 0; mstp_we = 0; med_sel = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_bits(input logic [4:0] b);
    {standby_en, low_speed_sel, direct_en, presc_src_sel, clk_chg_en} = b;
  endtask

  task automatic pulse_sleep(input logic [4:0] b);
    set_bits(b);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
  endtask

  // counts negedges with busy high; ends on the negedge after busy drops
  task automatic count_busy(output int n, input bit poke_r12);
    n = 0;
    while (settle_busy && n < 40000) begin
      n++;
      if (mode != 3'd2 && mode != 3'd3 && mode != 3'd4) chk("R3 mode during wait", mode, 2);
      if (poke_r12 && n == 10) begin
        set_bits(5'b11111);
        sleep_req = 1'b1;
      end else begin
        sleep_req = 1'b0;
      end
      @(negedge clk);
    end
    sleep_req = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 clk", clk_src, 0);
    chk("R1 busy", settle_busy, 0);
    chk("R1 dtx", dtx_pulse, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 mstp", mstp, 8'hFE);

    for (int v = 0; v < 10; v++) begin
      do_reset();
      @(negedge clk);
      pulse_sleep(VEC[v][11:7]);
      chk($sformatf("R2/R5/R7/R8/R9 vec%0d mode", v), mode, VEC[v][6:4]);
      chk($sformatf("R2/R7 vec%0d clk", v), clk_src, VEC[v][3:2]);
      chk($sformatf("R4 vec%0d dtx", v), dtx_pulse, VEC[v][1]);
      chk($sformatf("R8 vec%0d err", v), err_flag, VEC[v][0]);
      @(negedge clk);
      chk($sformatf("R4 vec%0d dtx one cycle", v), dtx_pulse, 0);
    end

    // R3 return to high speed with code 0, R12 request during wait ignored
    do_reset();
    @(negedge clk);
    pulse_sleep(5'b11110);
    pulse_sleep(5'b10110);
    chk("R3 busy starts", settle_busy, 1);
    chk("R4 no dtx at start", dtx_pulse, 0);
    count_busy(n, 1'b1);
    chk("R3 wait code0", n, 256);
    chk("R3 mode high", mode, 0);
    chk("R3 clk alt", clk_src, 1);
    chk("R4 dtx on return", dtx_pulse, 1);
    chk("R12 no error from ignored request", err_flag, 0);
    @(negedge clk);
    chk("R4 dtx falls", dtx_pulse, 0);

    // R3 with code 1
    settle_code = 3'd1;
    alt_clk_sel = 1'b0;
    pulse_sleep(5'b11110);
    pulse_sleep(5'b10110);
    count_busy(n, 1'b0);
    chk("R3 wait code1", n, 512);
    chk("R3 clk main", clk_src, 0);
    settle_code = 3'd0;
    alt_clk_sel = 1'b1;

    // R6 standby wake
    do_reset();
    @(negedge clk);
    pulse_sleep(5'b10000);
    pulse_wake();
    chk("R6 standby wait", settle_busy, 1);
    count_busy(n, 1'b0);
    chk("R6 standby count", n, 256);
    chk("R6 standby to high", mode, 0);
    chk("R6 clk alt", clk_src, 1);
    chk("R4 no dtx on wake", dtx_pulse, 0);

    // R6 watch wake with low speed set
    pulse_sleep(5'b10010);
    low_speed_sel = 1'b1;
    pulse_wake();
    chk("R6 watch to sub", mode, 2);
    chk("R6 watch clk sub", clk_src, 2);

    // R9 sleep from subactive returns to subactive; R12 ignored in sleep
    pulse_sleep(5'b00000);
    chk("R9 sleep from sub", mode, 5);
    pulse_sleep(5'b11111);
    chk("R12 ignored in sleep", mode, 5);
    chk("R12 no error in sleep", err_flag, 0);
    pulse_wake();
    chk("R9 back to sub", mode, 2);

    // R8 clear, and set wins over clear
    pulse_sleep(5'b11111);
    chk("R8 error from sub", err_flag, 1);
    chk("R8 mode held", mode, 2);
    err_clr = 1'b1;
    pulse_sleep(5'b11111);
    err_clr = 1'b0;
    chk("R8 set wins", err_flag, 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 cleared", err_flag, 0);

    // R11 medium speed
    do_reset();
    med_sel = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 medium", mode, 1);
    med_sel = 1'b0;
    @(negedge clk);
    chk("R11 back to high", mode, 0);

    // R10 module stop
    periph_req = 8'hFF;
    @(negedge clk);
    chk("R10 reset ack", periph_ack, 8'h01);
    mstp_wdata = 8'h0F;
    mstp_we = 1'b1;
    @(negedge clk);
    mstp_we = 1'b0;
    chk("R10 mstp written", mstp, 8'h0F);
    chk("R10 ack gated", periph_ack, 8'hF0);
    periph_req = 8'h3C;
    @(negedge clk);
    chk("R10 ack subset", periph_ack, 8'h30);

    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule